// File: doc/BRIEF.md
# Self-Routing Unicast Output Selector

This block makes the unicast routing decision for one switch element with 32 nibble-wide ports. For each input port it watches the start-of-cell flag. From the first two header nibbles it forms a five-bit destination, then widens that destination to an output group whose size is set by a three-bit configuration input. It grants the cell one output of that group that is live and not already taken. The decision is made while the rest of the cell is still streaming in, so the forwarding path can cut the cell straight through.

Inside a group, a 16-bit LFSR sets the starting member of a wrapping scan, which spreads traffic over parallel paths. Inputs that request in the same cycle are served one after another, starting from a rotating pointer. A granted output stays reserved for the length of a cell. When no output can be given, the block reports why: every member of the group is dead, or the live members are all taken. Result codes: 0 idle, 1 granted, 2 collision, 3 all outputs dead.

Top module: `uc_route_sel`

## Requirements
- R1: While reset is held and in the first cycle after it, every per-input result code reads 0 (idle).
- R2: A start-of-cell on input i in cycle t, with nibble0 on its header lane in cycle t and nibble1 in cycle t+1, gives a nonzero result code for input i in cycle t+2 only. The code is 0 in the cycles before and after.
- R3: The destination is D = the low 5 bits of {nibble1, nibble0}. With g = grp_cfg, and values 6 and 7 treated as 5, the group is the 2^g outputs whose upper 5-g bits equal those of D. A granted port always lies inside that group, and with g = 0 it equals D.
- R4: A granted port had out_alive high in cycle t+1.
- R5: If no member of the group is live in cycle t+1, the code is 3 (all outputs dead), whether or not any member is reserved.
- R6: No output is granted to two inputs in one cycle, and a granted output is not granted again for HOLD_CYC cycles. If the group has a live member but every live member is taken, the code is 2 (collision).
- R7: Inputs requesting in the same cycle are served in ascending index order, wrapping, from a pointer that is 0 after reset. After any cycle with a grant, the pointer moves to one past the first input served.
- R8: The scan inside a group starts at an offset taken from a 16-bit LFSR, which advances in each cycle that has a request, plus the input index. Repeated cells to a group of four live, free outputs therefore land on more than one member. If exactly one member is live and free, that member is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_soc | input | N_PORTS | Per-input start-of-cell flag |
| cell_nib | input | 4*N_PORTS | Per-input header nibble, lane i at bits 4i+3..4i |
| out_alive | input | N_PORTS | Per-output liveness flag |
| grp_cfg | input | 3 | log2 of the output group size (6 and 7 act as 5) |
| res_code | output | 2*N_PORTS | Per-input result code: 0 idle, 1 grant, 2 collision, 3 all dead |
| res_port | output | 5*N_PORTS | Per-input granted output index, valid with code 1 |

## Verification
The bench sends two inputs to one output at the same time, twice, separated by a full reservation period. The winner must change, so a pointer that never rotates, or one that moves the wrong way, gives the same winner both times. A group whose only live member is reserved must report collision and not all-dead, and a group with no live member must report all-dead. A design that confuses the two causes fails one of these cases. Setting grp_cfg to 7 with only port 31 alive catches a design that does not clamp the group size, because such a design reports the cell as dead. Repeated cells to an open group of four must land on more than one member, which exposes a random start point that never moves. Five inputs aimed at one group of four must get four distinct grants and one collision, which exposes a double grant.

// File: rtl/usel_pkg.sv
package usel_pkg;
    typedef enum logic [1:0] {
        RES_IDLE    = 2'd0,
        RES_GRANT   = 2'd1,
        RES_COLLIDE = 2'd2,
        RES_DEAD    = 2'd3
    } res_code_e;

    localparam int unsigned RND_W = 16;
    localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;
endpackage

// File: rtl/usel_hdr_capture.sv
module usel_hdr_capture #(
    parameter int unsigned N  = 32,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          soc_i,
    input  logic [N-1:0][3:0]     nib_i,
    output logic [N-1:0]          req_o,
    output logic [N-1:0][IW-1:0]  route_o
);
    typedef struct packed {
        logic [N-1:0]      cap;
        logic [N-1:0][3:0] nib0;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.cap = soc_i;
        for (int i = 0; i < N; i++) begin
            if (soc_i[i]) st_d.nib0[i] = nib_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Route uses the stored first nibble plus the live second nibble.
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_route
            assign route_o[g] = IW'({nib_i[g], st_q.nib0[g]});
        end
    endgenerate

    assign req_o = st_q.cap;
endmodule

// File: rtl/usel_lfsr.sv
module usel_lfsr #(
    parameter int unsigned IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    output logic [IW-1:0] rnd_o
);
    import usel_pkg::*;

    typedef struct packed {
        logic [RND_W-1:0] sr;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;
    logic     fb;

    always_comb begin
        st_d = st_q;
        fb   = st_q.sr[15] ^ st_q.sr[13] ^ st_q.sr[12] ^ st_q.sr[10];
        if (adv_i) st_d.sr = {st_q.sr[14:0], fb};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.sr <= RND_SEED;
        else        st_q    <= st_d;
    end

    // Fold every register bit into the offset.
    always_comb begin
        rnd_o = '0;
        for (int b = 0; b < int'(RND_W); b++) begin
            rnd_o[b % IW] = rnd_o[b % IW] ^ st_q.sr[b];
        end
    end
endmodule

// File: rtl/usel_busy.sv
module usel_busy #(
    parameter int unsigned N    = 32,
    parameter int unsigned HOLD = 16,
    parameter int unsigned CW   = $clog2(HOLD + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] load_i,
    output logic [N-1:0] busy_o
);
    typedef struct packed {
        logic [N-1:0][CW-1:0] cnt;
    } busy_st_t;

    busy_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int j = 0; j < N; j++) begin
            if (load_i[j])               st_d.cnt[j] = CW'(HOLD);
            else if (st_q.cnt[j] != '0)  st_d.cnt[j] = st_q.cnt[j] - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_busy
            assign busy_o[g] = (st_q.cnt[g] != '0);
        end
    endgenerate
endmodule

// File: rtl/usel_arb.sv
module usel_arb #(
    parameter int unsigned N  = 32,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]          req_i,
    input  logic [N-1:0][IW-1:0]  route_i,
    input  logic [N-1:0]          alive_i,
    input  logic [N-1:0]          busy_i,
    input  logic [2:0]            cfg_i,
    input  logic [IW-1:0]         ptr_i,
    input  logic [IW-1:0]         rnd_i,
    output logic [N-1:0][1:0]     code_o,
    output logic [N-1:0][IW-1:0]  port_o,
    output logic [N-1:0]          take_o,
    output logic                  any_grant_o,
    output logic [IW-1:0]         first_win_o
);
    import usel_pkg::*;

    logic [2:0]    cfg_eff;
    logic [IW-1:0] mask;
    logic [N-1:0]  taken;
    logic [IW-1:0] idx, base, off, cand, pick;
    logic          live, found;

    always_comb begin
        cfg_eff = (cfg_i > 3'(IW)) ? 3'(IW) : cfg_i;
        for (int b = 0; b < int'(IW); b++) mask[b] = (3'(b) < cfg_eff);

        taken       = busy_i;
        code_o      = '0;
        port_o      = '0;
        take_o      = '0;
        any_grant_o = 1'b0;
        first_win_o = '0;
        idx = '0; base = '0; off = '0; cand = '0; pick = '0;
        live = 1'b0; found = 1'b0;

        for (int s = 0; s < int'(N); s++) begin
            idx = ptr_i + IW'(s);
            if (req_i[idx]) begin
                base = route_i[idx] & ~mask;
                live = 1'b0;
                for (int m = 0; m < int'(N); m++) begin
                    if (((IW'(m) & ~mask) == base) && alive_i[m]) live = 1'b1;
                end
                off   = rnd_i + idx;
                found = 1'b0;
                pick  = '0;
                for (int k = 0; k < int'(N); k++) begin
                    cand = base | ((off + IW'(k)) & mask);
                    if (!found && (IW'(k) <= mask) && alive_i[cand] && !taken[cand]) begin
                        found = 1'b1;
                        pick  = cand;
                    end
                end
                if (!live) begin
                    code_o[idx] = RES_DEAD;
                end else if (!found) begin
                    code_o[idx] = RES_COLLIDE;
                end else begin
                    code_o[idx]  = RES_GRANT;
                    port_o[idx]  = pick;
                    taken[pick]  = 1'b1;
                    take_o[pick] = 1'b1;
                    if (!any_grant_o) begin
                        any_grant_o = 1'b1;
                        first_win_o = idx;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uc_route_sel.sv
module uc_route_sel #(
    parameter int unsigned N_PORTS  = 32,
    parameter int unsigned HOLD_CYC = 16,
    localparam int unsigned IW      = $clog2(N_PORTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_PORTS-1:0]      cell_soc,
    input  logic [4*N_PORTS-1:0]    cell_nib,
    input  logic [N_PORTS-1:0]      out_alive,
    input  logic [2:0]              grp_cfg,
    output logic [2*N_PORTS-1:0]    res_code,
    output logic [IW*N_PORTS-1:0]   res_port
);
    typedef struct packed {
        logic [IW-1:0]               ptr;
        logic [N_PORTS-1:0][1:0]     code;
        logic [N_PORTS-1:0][IW-1:0]  port;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [N_PORTS-1:0][3:0]     nib_lanes;
    logic [N_PORTS-1:0]          req;
    logic [N_PORTS-1:0][IW-1:0]  route;
    logic [N_PORTS-1:0]          busy;
    logic [N_PORTS-1:0]          take;
    logic [N_PORTS-1:0][1:0]     arb_code;
    logic [N_PORTS-1:0][IW-1:0]  arb_port;
    logic                        any_grant;
    logic [IW-1:0]               first_win;
    logic [IW-1:0]               rnd;

    assign nib_lanes = cell_nib;

    usel_hdr_capture #(.N(N_PORTS), .IW(IW)) u_cap (
        .clk(clk), .rst_n(rst_n), .soc_i(cell_soc), .nib_i(nib_lanes),
        .req_o(req), .route_o(route)
    );

    usel_lfsr #(.IW(IW)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .adv_i(|req), .rnd_o(rnd)
    );

    usel_busy #(.N(N_PORTS), .HOLD(HOLD_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .load_i(take), .busy_o(busy)
    );

    usel_arb #(.N(N_PORTS), .IW(IW)) u_arb (
        .req_i(req), .route_i(route), .alive_i(out_alive), .busy_i(busy),
        .cfg_i(grp_cfg), .ptr_i(st_q.ptr), .rnd_i(rnd),
        .code_o(arb_code), .port_o(arb_port), .take_o(take),
        .any_grant_o(any_grant), .first_win_o(first_win)
    );

    always_comb begin
        st_d      = st_q;
        st_d.code = arb_code;
        st_d.port = arb_port;
        if (any_grant) st_d.ptr = first_win + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_code = st_q.code;
    assign res_port = st_q.port;
endmodule

// File: rtl/usel_chk.sv
module usel_chk #(
    parameter int unsigned N_PORTS  = 32,
    parameter int unsigned HOLD_CYC = 16,
    localparam int unsigned IW      = $clog2(N_PORTS),
    localparam int unsigned AW      = $clog2(HOLD_CYC + 2)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_PORTS-1:0]      cell_soc,
    input logic [4*N_PORTS-1:0]    cell_nib,
    input logic [N_PORTS-1:0]      out_alive,
    input logic [2:0]              grp_cfg,
    input logic [2*N_PORTS-1:0]    res_code,
    input logic [IW*N_PORTS-1:0]   res_port
);
    import usel_pkg::*;

    logic [N_PORTS-1:0]          soc_p1, soc_p2, alive_p1;
    logic [4*N_PORTS-1:0]        nib_p1, nib_p2;
    logic [2:0]                  cfg_p1, cfg_eff;
    logic [IW-1:0]               mask;
    logic [N_PORTS-1:0]          grp_live, is_grant;
    logic [N_PORTS-1:0][IW-1:0]  dst, gport;
    logic [N_PORTS-1:0][N_PORTS-1:0] hits;
    logic [N_PORTS-1:0][AW-1:0]  age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soc_p1 <= '0; soc_p2 <= '0; alive_p1 <= '0;
            nib_p1 <= '0; nib_p2 <= '0; cfg_p1 <= '0;
        end else begin
            soc_p1 <= cell_soc; soc_p2 <= soc_p1; alive_p1 <= out_alive;
            nib_p1 <= cell_nib; nib_p2 <= nib_p1; cfg_p1 <= grp_cfg;
        end
    end

    always_comb begin
        cfg_eff = (cfg_p1 > 3'(IW)) ? 3'(IW) : cfg_p1;
        for (int b = 0; b < int'(IW); b++) mask[b] = (3'(b) < cfg_eff);
        hits = '0;
        for (int i = 0; i < int'(N_PORTS); i++) begin
            dst[i]      = IW'({nib_p1[4*i +: 4], nib_p2[4*i +: 4]});
            gport[i]    = res_port[IW*i +: IW];
            is_grant[i] = (res_code[2*i +: 2] == RES_GRANT);
            grp_live[i] = 1'b0;
            for (int m = 0; m < int'(N_PORTS); m++) begin
                if (((IW'(m) & ~mask) == (dst[i] & ~mask)) && alive_p1[m]) grp_live[i] = 1'b1;
            end
            if (is_grant[i]) hits[gport[i]][i] = 1'b1;
        end
    end

    // Edges since each output was last handed out, saturating.
    always_ff @(posedge clk) begin
        for (int j = 0; j < int'(N_PORTS); j++) begin
            if (!rst_n)                 age[j] <= AW'(HOLD_CYC + 1);
            else if (|hits[j])          age[j] <= '0;
            else if (age[j] < AW'(HOLD_CYC + 1)) age[j] <= age[j] + 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_PORTS; g++) begin : g_in
            // R2: result appears exactly two cycles after start-of-cell
            a_r2_result_after_soc: assert property (@(posedge clk) disable iff (!rst_n)
                soc_p2[g] |-> (res_code[2*g +: 2] != RES_IDLE));
            a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
                (res_code[2*g +: 2] != RES_IDLE) |-> soc_p2[g]);
            // R3: grant lies in the addressed group
            a_r3_in_group: assert property (@(posedge clk) disable iff (!rst_n)
                is_grant[g] |-> ((gport[g] & ~mask) == (dst[g] & ~mask)));
            // R4: grant goes to a live output
            a_r4_port_alive: assert property (@(posedge clk) disable iff (!rst_n)
                is_grant[g] |-> alive_p1[gport[g]]);
            // R5: all-dead cause only when no member is live
            a_r5_dead_cause: assert property (@(posedge clk) disable iff (!rst_n)
                (res_code[2*g +: 2] == RES_DEAD) |-> !grp_live[g]);
            // R6: collision only when a live member exists
            a_r6_collide_cause: assert property (@(posedge clk) disable iff (!rst_n)
                (res_code[2*g +: 2] == RES_COLLIDE) |-> grp_live[g]);
        end
        for (g = 0; g < N_PORTS; g++) begin : g_out
            // R6: at most one owner per output per cycle
            a_r6_unique_grant: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(hits[g]) <= 1);
            // R6: output stays reserved for the hold window
            a_r6_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
                (|hits[g]) |-> (age[g] >= AW'(HOLD_CYC)));
        end
    endgenerate
endmodule

bind uc_route_sel usel_chk #(.N_PORTS(N_PORTS), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .cell_soc(cell_soc), .cell_nib(cell_nib),
    .out_alive(out_alive), .grp_cfg(grp_cfg), .res_code(res_code), .res_port(res_port)
);

// File: tb/uc_route_sel_tb.sv
module uc_route_sel_tb;
    localparam int N    = 32;
    localparam int HOLD = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   cell_soc = '0;
    logic [4*N-1:0] cell_nib = '0;
    logic [N-1:0]   out_alive = '1;
    logic [2:0]     grp_cfg = '0;
    logic [2*N-1:0] res_code;
    logic [5*N-1:0] res_port;

    int n_chk = 0, n_bad = 0;
    logic [4:0] rt [N];
    logic [1:0] got_c [N];
    logic [4:0] got_p [N];
    logic [1:0] mid_c [N];

    always #10 clk = ~clk;

    uc_route_sel #(.N_PORTS(N), .HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .cell_soc(cell_soc), .cell_nib(cell_nib),
        .out_alive(out_alive), .grp_cfg(grp_cfg), .res_code(res_code), .res_port(res_port)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cell_soc = '0; cell_nib = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fire(input logic [N-1:0] m);
        @(negedge clk);
        cell_soc = m;
        for (int i = 0; i < N; i++) cell_nib[4*i +: 4] = rt[i][3:0];
        @(negedge clk);
        for (int i = 0; i < N; i++) mid_c[i] = res_code[2*i +: 2];
        cell_soc = '0;
        for (int i = 0; i < N; i++) cell_nib[4*i +: 4] = {3'b000, rt[i][4]};
        @(negedge clk);
        cell_nib = '0;
        for (int i = 0; i < N; i++) begin
            got_c[i] = res_code[2*i +: 2];
            got_p[i] = res_port[5*i +: 5];
        end
    endtask

    task automatic settle();
        repeat (HOLD + 4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(res_code == '0, "R1 idle in reset", int'(res_code != '0), 0);
        do_reset();
        chk(res_code == '0, "R1 idle after reset", int'(res_code != '0), 0);
    endtask

    task automatic t_timing();
        grp_cfg = 3'd0; out_alive = '1;
        rt[2] = 5'd17;
        fire(N'(1) << 2);
        chk(mid_c[2] == 2'd0, "R2 idle at t+1", mid_c[2], 0);
        chk(got_c[2] == 2'd1, "R2 grant at t+2", got_c[2], 1);
        chk(got_p[2] == 5'd17, "R3 group of one", got_p[2], 17);
        @(negedge clk);
        chk(res_code[5:4] == 2'd0, "R2 idle at t+3", res_code[5:4], 0);
        settle();
    endtask

    task automatic t_clamp();
        out_alive = 32'h8000_0000;
        rt[0] = 5'd0;
        grp_cfg = 3'd7;
        fire(N'(1));
        chk(got_c[0] == 2'd1 && got_p[0] == 5'd31, "R3 cfg 7 acts as 5", got_p[0], 31);
        settle();
        grp_cfg = 3'd5;
        fire(N'(1));
        chk(got_c[0] == 2'd1 && got_p[0] == 5'd31, "R3 cfg 5 whole range", got_p[0], 31);
        settle();
        out_alive = '1;
    endtask

    task automatic t_dead_vs_collide();
        grp_cfg = 3'd2;
        out_alive = '1;
        out_alive[11:8]  = 4'b0000;
        out_alive[15:12] = 4'b0010;
        rt[4] = 5'd9;
        fire(N'(1) << 4);
        chk(got_c[4] == 2'd3, "R5 all dead", got_c[4], 3);
        rt[1] = 5'd15;
        fire(N'(1) << 1);
        chk(got_c[1] == 2'd1 && got_p[1] == 5'd13, "R8 single live member", got_p[1], 13);
        rt[2] = 5'd14;
        fire(N'(1) << 2);
        chk(got_c[2] == 2'd2, "R6 live member reserved gives collision", got_c[2], 2);
        rt[3] = 5'd8;
        fire(N'(1) << 3);
        chk(got_c[3] == 2'd3, "R5 dead group while others reserved", got_c[3], 3);
        settle();
        out_alive = '1;
    endtask

    task automatic t_priority();
        do_reset();
        grp_cfg = 3'd0; out_alive = '1;
        rt[3] = 5'd20; rt[5] = 5'd20;
        fire((N'(1) << 3) | (N'(1) << 5));
        chk(got_c[3] == 2'd1, "R7 lower input wins from pointer 0", got_c[3], 1);
        chk(got_c[5] == 2'd2, "R6 loser reports collision", got_c[5], 2);
        settle();
        fire((N'(1) << 3) | (N'(1) << 5));
        chk(got_c[5] == 2'd1, "R7 pointer rotated past winner", got_c[5], 1);
        chk(got_c[3] == 2'd2, "R7 former winner now collides", got_c[3], 2);
        settle();
        rt[8] = 5'd20;
        fire(N'(1) << 8);
        chk(got_c[8] == 2'd1 && got_p[8] == 5'd20, "R6 output released after hold", got_p[8], 20);
        rt[9] = 5'd20;
        fire(N'(1) << 9);
        chk(got_c[9] == 2'd2, "R6 output held after grant", got_c[9], 2);
        settle();
    endtask

    task automatic t_fill();
        logic [N-1:0] used;
        int ng, nc;
        bit dup, outside;
        grp_cfg = 3'd2; out_alive = '1;
        for (int i = 10; i < 15; i++) rt[i] = 5'd24;
        fire(N'(5'b11111) << 10);
        used = '0; ng = 0; nc = 0; dup = 0; outside = 0;
        for (int i = 10; i < 15; i++) begin
            if (got_c[i] == 2'd1) begin
                ng++;
                if (used[got_p[i]]) dup = 1;
                used[got_p[i]] = 1'b1;
                if (got_p[i] < 5'd24 || got_p[i] > 5'd27) outside = 1;
            end else if (got_c[i] == 2'd2) nc++;
        end
        chk(ng == 4, "R6 four grants in group of four", ng, 4);
        chk(nc == 1, "R6 fifth input collides", nc, 1);
        chk(!dup, "R6 grants distinct", int'(dup), 0);
        chk(!outside, "R3 grants inside group", int'(outside), 0);
        settle();
    endtask

    task automatic t_spread();
        logic [N-1:0] seen = '0;
        bit outside = 0;
        grp_cfg = 3'd2; out_alive = '1;
        rt[0] = 5'd5;
        for (int r = 0; r < 20; r++) begin
            fire(N'(1));
            if (got_c[0] != 2'd1 || got_p[0] < 5'd4 || got_p[0] > 5'd7) outside = 1;
            else seen[got_p[0]] = 1'b1;
            settle();
        end
        chk(!outside, "R3 spread grants inside group", int'(outside), 0);
        chk($countones(seen) > 1, "R8 more than one member used", $countones(seen), 2);
    endtask

    task automatic t_liveness();
        bit bad = 0;
        grp_cfg = 3'd3;
        out_alive = '1;
        out_alive[23:16] = 8'b0010_0100;
        rt[6] = 5'd16;
        for (int r = 0; r < 6; r++) begin
            fire(N'(1) << 6);
            if (got_c[6] != 2'd1 || (got_p[6] != 5'd18 && got_p[6] != 5'd21)) bad = 1;
            settle();
        end
        chk(!bad, "R4 only live members granted", int'(bad), 0);
        out_alive = '1;
    endtask

    initial begin
        for (int i = 0; i < N; i++) rt[i] = '0;
        t_reset();
        t_timing();
        t_clamp();
        t_dead_vs_collide();
        t_priority();
        t_fill();
        t_spread();
        t_liveness();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule